// File: doc/BRIEF.md
# Multi-order PRBS generator and checker

This block is a serial pseudo-random bit sequence unit that handles one bit per clock. In generate mode it runs a linear feedback shift register and puts the newest bit on `tx_bit`. Three orders can be selected at run time: 7, 15 and 31. The unit is used as an on-chip test pattern source for links and memory self-test, wherever a deterministic stream with good run-length properties is needed.

In check mode the same shift register works as a self-synchronizing receiver, so no reference stream is needed. It first takes in as many raw received bits as the order length. From then on it predicts each incoming bit from the recurrence and compares that prediction with the received bit. Each disagreement raises a one-cycle flag and adds one to a saturating 10-bit count. After lock the register is fed from the prediction, not from the raw input. A single corrupted bit therefore costs exactly one count and does not set off a burst of errors.

An injection input inverts the received bit before it is checked, so error paths can be tested on purpose. When correction is selected, `tx_bit` carries the predicted stream, which is free of errors, while checking and counting go on.

Top module: `prbs_unit`

## Requirements
- R1: With `check_mode`=0 and `enable`=1, each clock shifts a new bit into the newest stage. The new bit is stage N XOR stage K, where `order_sel` 0 selects (N,K)=(7,6), 1 selects (15,14), and 2 or 3 selects (31,28). `tx_bit` shows the newest stage. After reset only the newest stage holds a one, so `tx_bit`=1.
- R2: The generated stream of order N repeats with period 2^N-1. Within one period of order 7, every nonzero 7-bit window appears exactly once, no run of zeros is longer than 6, and no run of ones is longer than 7.
- R3: If the N-stage window is all zeros on a generate-mode clock, the register reloads the single-one seed, so `tx_bit` becomes 1 on that clock.
- R4: On the first N enabled clocks after `check_mode` rises, or after reset, the register loads the received bit. No error is flagged or counted during these clocks.
- R5: After those N clocks, on each enabled check-mode clock the received bit is compared with the predicted bit (stage N XOR stage K). `err_flag` is high during the cycle after the clock exactly when they differ.
- R6: While `inject`=1, the received bit is inverted before it is compared and before it is stored.
- R7: Each erroneous bit adds exactly one to `err_count`, including errors on consecutive clocks. Because the register takes in the predicted bit, a single flipped input bit gives exactly one count.
- R8: `err_count` saturates at 1023 and does not wrap.
- R9: `err_clear`=1 sets `err_count` to 0 on the next clock, and takes precedence over an increment on that clock.
- R10: With `check_mode`=1 and `correct_en`=1, after lock `tx_bit` shows the predicted bit, which is the error-free stream, one clock after that bit was received.
- R11: With `enable`=0, the register, `tx_bit` and `err_count` keep their values (except for a clear), and `err_flag` is 0.
- R12: With `check_mode`=1 and `correct_en`=0, `tx_bit` shows the received bit after injection, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 2 | 0: order 7, 1: order 15, 2/3: order 31 |
| enable | input | 1 | Advance the unit this clock |
| check_mode | input | 1 | 0 generate, 1 check |
| correct_en | input | 1 | In check mode, output the corrected stream |
| err_clear | input | 1 | Clear the error counter |
| inject | input | 1 | Invert the received bit |
| rx_bit | input | 1 | Received serial bit |
| tx_bit | output | 1 | Generated, corrected or echoed bit |
| err_flag | output | 1 | One-cycle pulse per detected error |
| err_count | output | 10 | Saturating error count |

## Verification
The embedded properties check the following on every clock: the counter moves by at most one step and saturates, each flag pulse matches exactly one increment, clear wins, the counter stays silent during acquisition, state is frozen while disabled, and the generate-mode window never becomes all zeros. The bench scenarios cover what a cycle-local property cannot show: the exact stream for every order, the period and run-length properties, recovery from a zero state, and the correct count and corrected output under random flips, injected errors and bursts on consecutive clocks.

// File: rtl/prbs_unit.sv
module prbs_unit #(
  parameter int          CNT_W = 10,
  parameter logic [30:0] SEED  = 31'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       order_sel,
  input  logic             enable,
  input  logic             check_mode,
  input  logic             correct_en,
  input  logic             err_clear,
  input  logic             inject,
  input  logic             rx_bit,
  output logic             tx_bit,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [30:0] sreg;
  logic [4:0]  acq_cnt;
  logic        rx_q;
  logic [4:0]  n_len, k_tap;

  always_comb begin
    case (order_sel)
      2'd0:    begin n_len = 5'd7;  k_tap = 5'd6;  end
      2'd1:    begin n_len = 5'd15; k_tap = 5'd14; end
      default: begin n_len = 5'd31; k_tap = 5'd28; end
    endcase
  end

  logic [30:0] win_mask;
  logic        pred, rx_eff, locked, zero_win, chk_act, mismatch;

  assign win_mask = 31'h7FFF_FFFF >> (5'd31 - n_len);
  assign pred     = sreg[n_len - 5'd1] ^ sreg[k_tap - 5'd1];
  assign rx_eff   = rx_bit ^ inject;
  assign locked   = acq_cnt >= n_len;
  assign zero_win = (sreg & win_mask) == 31'h0;
  assign chk_act  = enable && check_mode && locked;
  assign mismatch = rx_eff ^ pred;
  assign tx_bit   = (check_mode && !correct_en) ? rx_q : sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg      <= SEED;
      acq_cnt   <= '0;
      rx_q      <= 1'b0;
      err_flag  <= 1'b0;
      err_count <= '0;
    end else begin
      err_flag <= chk_act && mismatch;
      if (err_clear)
        err_count <= '0;
      else if (chk_act && mismatch && err_count != CNT_MAX)
        err_count <= err_count + 1'b1;

      if (!check_mode)
        acq_cnt <= '0;
      else if (enable && !locked)
        acq_cnt <= acq_cnt + 5'd1;

      if (enable) begin
        rx_q <= rx_eff;
        if (check_mode)
          sreg <= {sreg[29:0], locked ? pred : rx_eff};
        else if (zero_win)
          sreg <= SEED;
        else
          sreg <= {sreg[29:0], pred};
      end
    end
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !err_clear) |=> err_count == CNT_MAX);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> err_count == '0);

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clear |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  p_flag_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !$past(err_clear) && $past(err_count) != CNT_MAX) |-> err_count == $past(err_count) + 1'b1);

  p_acq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !err_flag);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !err_clear) |=> ($stable(sreg) && $stable(rx_q) && $stable(err_count) && !err_flag));

  p_no_lockup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !check_mode) |=> (sreg & $past(win_mask)) != 31'h0);
endmodule

// File: tb/prbs_unit_bench.sv
module prbs_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, enable, check_mode, correct_en, err_clear, inject, rx_bit;
  logic [1:0] order_sel;
  logic tx_bit, err_flag;
  logic [9:0] err_count;

  prbs_unit u_prbs_unit (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .enable(enable),
    .check_mode(check_mode), .correct_en(correct_en), .err_clear(err_clear),
    .inject(inject), .rx_bit(rx_bit), .tx_bit(tx_bit), .err_flag(err_flag),
    .err_count(err_count)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [30:0] m;
  int cnt;

  function automatic int ord_n(input logic [1:0] o);
    return (o == 2'd0) ? 7 : (o == 2'd1) ? 15 : 31;
  endfunction
  function automatic int ord_k(input logic [1:0] o);
    return (o == 2'd0) ? 6 : (o == 2'd1) ? 14 : 28;
  endfunction
  function automatic logic nxt(input logic [30:0] s, input logic [1:0] o);
    return s[ord_n(o)-1] ^ s[ord_k(o)-1];
  endfunction
  function automatic logic [30:0] wmask(input logic [1:0] o);
    return 31'h7FFF_FFFF >> (31 - ord_n(o));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] o);
    @(negedge clk);
    rst_n = 0; enable = 0; check_mode = 0; correct_en = 0;
    err_clear = 0; inject = 0; rx_bit = 0; order_sel = o;
    repeat (3) step();
    rst_n = 1;
    m = 31'h1;
    cnt = 0;
  endtask

  task automatic gen_run(input logic [1:0] o, input int cycles);
    do_reset(o);
    chk(tx_bit == 1'b1, "R1 reset tx", tx_bit, 1);
    chk(err_count == 0 && err_flag == 0, "R8 reset count", err_count, 0);
    for (int i = 0; i < cycles; i++) begin
      logic en;
      en = ($urandom % 5) != 0;
      enable = en;
      step();
      if (en) m = ((m & wmask(o)) == 0) ? 31'h1 : {m[29:0], nxt(m, o)};
      chk(tx_bit == m[0], en ? "R1 gen bit" : "R11 gen hold", tx_bit, m[0]);
    end
  endtask

  task automatic acquire(input logic [1:0] o, input logic corr);
    do_reset(o);
    check_mode = 1; correct_en = corr; enable = 1;
    m = $urandom & wmask(o);
    if (m == 0) m = 31'h1;
    for (int i = 0; i < ord_n(o); i++) begin
      logic b;
      b = nxt(m, o);
      m = {m[29:0], b};
      rx_bit = b;
      step();
      chk(err_flag == 0 && err_count == 0, "R4 acquisition quiet", err_count, 0);
    end
  endtask

  task automatic chk_run(input logic [1:0] o, input logic corr, input int cycles);
    logic prev_tx;
    acquire(o, corr);
    prev_tx = tx_bit;
    for (int i = 0; i < cycles; i++) begin
      logic b, flip, inj, e, en;
      en = ($urandom % 10) != 0;
      flip = ($urandom % 8) == 0;
      inj = ($urandom % 8) == 0;
      if (i >= 50 && i < 53) begin en = 1; flip = 0; inj = 1; end
      if (i >= 80 && i < 82) begin en = 1; flip = 1; inj = 0; end
      enable = en;
      if (en) begin
        b = nxt(m, o);
        m = {m[29:0], b};
        rx_bit = b ^ flip;
        inject = inj;
        e = flip ^ inj;
        step();
        if (e) cnt++;
        chk(err_flag == e, inj ? "R6 injected flag" : "R5 flag", err_flag, e);
        chk(err_count == cnt, "R7 count", err_count, cnt);
        if (corr) chk(tx_bit == b, "R10 corrected", tx_bit, b);
        else chk(tx_bit == (b ^ e), "R12 echo", tx_bit, b ^ e);
      end else begin
        rx_bit = $urandom % 2;
        inject = $urandom % 2;
        step();
        chk(err_flag == 0 && err_count == cnt && tx_bit == prev_tx,
            "R11 idle hold", err_count, cnt);
      end
      prev_tx = tx_bit;
    end
    inject = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    gen_run(2'd0, 300);
    gen_run(2'd1, 300);
    gen_run(2'd2, 300);
    gen_run(2'd3, 100);

    begin : period7
      logic b [0:140];
      bit seen [0:127];
      int zr, orun, mz, mo;
      do_reset(2'd0);
      enable = 1;
      b[0] = tx_bit;
      for (int t = 1; t <= 140; t++) begin step(); b[t] = tx_bit; end
      for (int t = 0; t < 14; t++)
        chk(b[t] == b[t+127], "R2 period 127", b[t+127], b[t]);
      for (int t = 0; t < 128; t++) seen[t] = 0;
      for (int t = 0; t < 127; t++) begin
        int w;
        w = 0;
        for (int j = 0; j < 7; j++) w = (w << 1) | int'(b[t+j]);
        seen[w] = 1;
      end
      for (int w = 0; w < 128; w++)
        chk(seen[w] == (w != 0), "R2 window coverage", seen[w], w != 0);
      zr = 0; orun = 0; mz = 0; mo = 0;
      for (int t = 0; t < 127 + 14; t++) begin
        if (b[t]) begin orun++; zr = 0; end else begin zr++; orun = 0; end
        if (zr > mz) mz = zr;
        if (orun > mo) mo = orun;
      end
      chk(mz == 6, "R2 zero run", mz, 6);
      chk(mo == 7, "R2 one run", mo, 7);
    end

    begin : period15
      logic first [0:14];
      do_reset(2'd1);
      enable = 1;
      first[0] = tx_bit;
      for (int t = 1; t < 32767 + 15; t++) begin
        step();
        if (t < 15) first[t] = tx_bit;
        if (t >= 32767) chk(tx_bit == first[t-32767], "R2 period 32767", tx_bit, first[t-32767]);
      end
    end

    do_reset(2'd0);
    check_mode = 1; enable = 1; rx_bit = 0;
    repeat (7) step();
    check_mode = 0;
    step();
    chk(tx_bit == 1'b1, "R3 zero reseed", tx_bit, 1);
    m = 31'h1;
    for (int i = 0; i < 20; i++) begin
      step();
      m = {m[29:0], nxt(m, 2'd0)};
      chk(tx_bit == m[0], "R3 after reseed", tx_bit, m[0]);
    end

    chk_run(2'd0, 1'b0, 400);
    chk_run(2'd1, 1'b1, 400);
    chk_run(2'd2, 1'b1, 400);
    chk_run(2'd2, 1'b0, 200);

    acquire(2'd0, 1'b1);
    inject = 1;
    for (int i = 0; i < 1030; i++) begin
      logic b;
      b = nxt(m, 2'd0);
      m = {m[29:0], b};
      rx_bit = b;
      step();
      if (cnt < 1023) cnt++;
      if (i == 1021 || i >= 1027) chk(err_count == cnt, "R8 saturation", err_count, cnt);
      if (i == 1029) chk(tx_bit == b, "R10 corrected under injection", tx_bit, b);
    end
    err_clear = 1;
    begin
      logic b;
      b = nxt(m, 2'd0); m = {m[29:0], b}; rx_bit = b;
    end
    step();
    chk(err_count == 0, "R9 clear wins", err_count, 0);
    chk(err_flag == 1, "R6 flag during clear", err_flag, 1);
    err_clear = 0;
    begin
      logic b;
      b = nxt(m, 2'd0); m = {m[29:0], b}; rx_bit = b;
    end
    step();
    chk(err_count == 1, "R9 count after clear", err_count, 1);
    inject = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule